// File: doc/BRIEF.md
# Oversampled SPI Slave Receiver

This block is an SPI slave (clock idle low, data sampled on the rising serial-clock edge, mode 0) that runs entirely on the fast system clock. The serial clock pin never drives a flip-flop clock input. Chip select, serial clock and the incoming data line are each passed through a short chain of system-clock flops and then through a two-entry history. Comparing the newest sample with the one before it gives one-cycle rising and falling strobes, and these strobes act as clock enables for the shift logic.

Incoming bits are assembled most significant bit first. When a byte completes, the block presents it on a parallel output together with a one-cycle valid pulse. The outgoing line is loaded from a transmit byte that the block captures when chip select goes active and again after every completed byte. Each capture raises a one-cycle ready pulse, which tells the core it may supply the next byte. The system clock must run at least four times faster than the serial clock.

Top module: `spi_sampled_slave`

## Requirements
- R1: While reset is high and after it is released with no bus activity, rx_valid_o, tx_ready_o and miso_o are 0 and rx_data_o is 0x00.
- R2: Each of sclk_i, cs_n_i and mosi_i reaches the shift logic only after SYNC_STAGES system-clock flops plus one history flop. Every output follows a cycle-exact model of that latency.
- R3: Each low-to-high transition of sclk_i shifts exactly one bit, however long sclk_i then stays high.
- R4: Bits are taken most significant bit first. On the eighth rising edge of a byte, the byte appears on rx_data_o and rx_valid_o is high for exactly one system clock cycle.
- R5: While cs_n_i is high (inactive), the bit count returns to zero and a partial byte is discarded without any rx_valid_o pulse.
- R6: After cs_n_i falls, miso_o shows bit 7 of the captured byte. Each falling sclk_i edge then advances miso_o to the next lower bit.
- R7: tx_data_i is captured when chip select becomes active and at the falling sclk_i edge that follows each completed byte. Every capture gives a one-cycle tx_ready_o pulse, so a full frame of N bytes gives N+1 pulses.
- R8: miso_o is 0 while chip select is inactive.
- R9: Bytes are received correctly with sclk_i high for 2 and low for 2 system clock cycles (a 4:1 clock ratio).
- R10: Several bytes can be transferred within one chip-select frame, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all flops use it |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin, sampled as data |
| cs_n_i | input | 1 | Chip select pin, active low |
| mosi_i | input | 1 | Serial data from the master |
| tx_data_i | input | DATA_W | Byte to be sent to the master |
| miso_o | output | 1 | Serial data to the master |
| tx_ready_o | output | 1 | One-cycle pulse when tx_data_i has been captured |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o is new |

## Verification
A frame aborted after five bits is followed by a clean byte. A design that kept the count would deliver a byte shifted by five bits, or a spurious valid pulse. Stretched serial-clock high phases expose an edge detector that works on levels, because it would shift the same bit many times. The 4:1 clock-ratio frame catches a history or alignment error that drops or slips bits. The master samples miso on multi-byte frames, which catches a byte that is reloaded on the wrong edge, or a shift that runs one bit early or late. A cycle-exact model, compared on every clock, flags any extra or missing synchronizer stage.

// File: rtl/ss_pkg.sv
package ss_pkg;
  // Bundle of the three sampled SPI input lines
  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic mosi;
  } spi_lines_t;

  // Idle levels: serial clock low, chip select inactive (high), data low
  localparam spi_lines_t LINES_IDLE = '{sclk: 1'b0, cs_n: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int             STAGES = 3,
  parameter int             WIDTH  = 3,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // Chain of flops; entry 0 samples the pin, the last entry feeds logic.
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= IDLE;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

  // R2
  sync_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q_o == IDLE));
endmodule

// File: rtl/ss_edge.sv
module ss_edge
  import ss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  spi_lines_t lines_i,
  output logic       sel_o,
  output logic       cs_fall_o,
  output logic       sclk_rise_o,
  output logic       sclk_fall_o,
  output logic       bit_o
);
  // History: newest synchronized sample and the one before it
  spi_lines_t cur_q;
  logic       prev_sclk_q;
  logic       prev_cs_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= LINES_IDLE;
      prev_sclk_q <= LINES_IDLE.sclk;
      prev_cs_n_q <= LINES_IDLE.cs_n;
    end else begin
      cur_q       <= lines_i;
      prev_sclk_q <= cur_q.sclk;
      prev_cs_n_q <= cur_q.cs_n;
    end
  end

  assign sel_o       = ~cur_q.cs_n;
  assign cs_fall_o   = prev_cs_n_q & ~cur_q.cs_n;
  assign sclk_rise_o = cur_q.sclk & ~prev_sclk_q;
  assign sclk_fall_o = ~cur_q.sclk & prev_sclk_q;
  assign bit_o       = cur_q.mosi;

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_rise_o |=> !sclk_rise_o);
endmodule

// File: rtl/ss_rx.sv
module ss_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] next_sh;

  assign next_sh = {shreg_q[DATA_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!sel_i) begin
        shreg_q <= '0;
        cnt_q   <= '0;
      end else if (rise_i) begin
        shreg_q <= next_sh;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          rx_data_o  <= next_sh;
          rx_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);
  // R5
  rx_framed_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(sel_i));
endmodule

// File: rtl/ss_tx.sv
module ss_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              cs_fall_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              miso_o,
  output logic              tx_ready_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      reload_q   <= 1'b0;
      miso_o     <= 1'b0;
      tx_ready_o <= 1'b0;
    end else begin
      tx_ready_o <= 1'b0;
      if (!sel_i) begin
        shreg_q  <= '0;
        cnt_q    <= '0;
        reload_q <= 1'b0;
        miso_o   <= 1'b0;
      end else if (cs_fall_i) begin
        shreg_q    <= tx_data_i;
        miso_o     <= tx_data_i[DATA_W-1];
        tx_ready_o <= 1'b1;
        cnt_q      <= '0;
        reload_q   <= 1'b0;
      end else begin
        if (rise_i) begin
          if (cnt_q == LAST) begin
            cnt_q    <= '0;
            reload_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (fall_i) begin
          if (reload_q) begin
            shreg_q    <= tx_data_i;
            miso_o     <= tx_data_i[DATA_W-1];
            tx_ready_o <= 1'b1;
            reload_q   <= 1'b0;
          end else begin
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            miso_o  <= shreg_q[DATA_W-2];
          end
        end
      end
    end
  end

  // R7
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |=> !tx_ready_o);
endmodule

// File: rtl/spi_sampled_slave.sv
module spi_sampled_slave
  import ss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              miso_o,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int LINES_W = $bits(spi_lines_t);

  spi_lines_t pins_w, synced_w;
  logic sel_w, cs_fall_w, rise_w, fall_w, bit_w;

  assign pins_w = '{sclk: sclk_i, cs_n: cs_n_i, mosi: mosi_i};

  ss_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES_W), .IDLE(LINES_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_w), .q_o(synced_w)
  );

  ss_edge u_edge (
    .clk(clk), .rst(rst), .lines_i(synced_w),
    .sel_o(sel_w), .cs_fall_o(cs_fall_w),
    .sclk_rise_o(rise_w), .sclk_fall_o(fall_w), .bit_o(bit_w)
  );

  ss_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .sel_i(sel_w), .rise_i(rise_w), .bit_i(bit_w),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  ss_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .sel_i(sel_w), .cs_fall_i(cs_fall_w),
    .rise_i(rise_w), .fall_i(fall_w), .tx_data_i(tx_data_i),
    .miso_o(miso_o), .tx_ready_o(tx_ready_o)
  );

  // R3
  rx_from_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(rise_w));
  // R7
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |-> $past(cs_fall_w || fall_w));
endmodule

// File: tb/spi_sampled_slave_tb.sv
module spi_sampled_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 3;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk_i = 1'b0, cs_n_i = 1'b1, mosi_i = 1'b0;
  logic [7:0] tx_data_i = 8'h3C;
  logic       miso_o, tx_ready_o, rx_valid_o;
  logic [7:0] rx_data_o;

  int n_chk = 0, n_bad = 0, cyc = 0, tx_idx = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sampled_slave #(.DATA_W(8), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .mosi_i(mosi_i),
    .tx_data_i(tx_data_i), .miso_o(miso_o), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model: delay queue + behavioural state -------
  logic [2:0] lq[$];
  int m_acc, m_bits, m_rxd, m_txsh, m_txbits;
  bit m_rxv, m_rdy, m_miso, m_pend;

  always @(posedge clk) begin
    logic [2:0] cur, prv;
    bit sel, up, dn, csf;
    if (rst) begin
      lq.delete();
      for (int i = 0; i < SYNC + 3; i++) lq.push_back(3'b010);
      m_acc = 0; m_bits = 0; m_rxd = 0; m_txsh = 0; m_txbits = 0;
      m_rxv = 0; m_rdy = 0; m_miso = 0; m_pend = 0;
    end else begin
      lq.push_front({sclk_i, cs_n_i, mosi_i});
      void'(lq.pop_back());
      cur = lq[SYNC+1];
      prv = lq[SYNC+2];
      sel = !cur[1];
      up  = cur[2] && !prv[2];
      dn  = !cur[2] && prv[2];
      csf = prv[1] && !cur[1];
      m_rxv = 0;
      m_rdy = 0;
      if (!sel) begin
        m_acc = 0; m_bits = 0; m_txsh = 0; m_txbits = 0; m_pend = 0; m_miso = 0;
      end else begin
        if (up) begin
          m_acc = ((m_acc << 1) | int'(cur[0])) & 255;
          m_bits++;
          if (m_bits == 8) begin m_rxd = m_acc; m_rxv = 1; m_bits = 0; end
        end
        if (csf) begin
          m_txsh = tx_data_i; m_miso = tx_data_i[7]; m_rdy = 1;
          m_txbits = 0; m_pend = 0;
        end else begin
          if (up) begin
            m_txbits++;
            if (m_txbits == 8) begin m_txbits = 0; m_pend = 1; end
          end
          if (dn) begin
            if (m_pend) begin
              m_txsh = tx_data_i; m_miso = tx_data_i[7]; m_rdy = 1; m_pend = 0;
            end else begin
              m_txsh = (m_txsh << 1) & 255;
              m_miso = m_txsh[7];
            end
          end
        end
      end
    end
  end

  // R2: cycle-exact comparison of every output on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({rx_valid_o, tx_ready_o, miso_o, rx_data_o} ==
          {m_rxv, m_rdy, m_miso, 8'(m_rxd)}, "R2 model",
          {rx_valid_o, tx_ready_o, miso_o, rx_data_o},
          {m_rxv, m_rdy, m_miso, 8'(m_rxd)});
    end
  end

  // ---------------- monitors and transmit-byte supplier --------------------
  int rx_got_q[$];
  int cap_q[$];

  always @(negedge clk) begin
    if (!rst && rx_valid_o) rx_got_q.push_back(int'(rx_data_o));
    if (!rst && tx_ready_o) begin
      cap_q.push_back(int'(tx_data_i));
      tx_idx++;
      tx_data_i = 8'((tx_idx * 37) ^ 8'hA5);
    end
  end

  // ---------------- SPI master ---------------------------------------------
  logic [7:0] sb[4];
  int miso_got[4];

  task automatic frame(input int n, input int hp, input int stretch, input int cut,
                       input bit chk_miso, input string req);
    int bits = 0;
    bit stop = 0;
    rx_got_q.delete();
    cap_q.delete();
    @(negedge clk);
    cs_n_i = 1'b0;
    mosi_i = sb[0][7];
    repeat (2*hp + 8) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      logic [7:0] rcv = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        if (!stop) begin
          mosi_i = sb[b][i];
          repeat (hp) @(negedge clk);
          sclk_i = 1'b1;
          rcv = {rcv[6:0], miso_o};
          repeat (hp + stretch) @(negedge clk);
          sclk_i = 1'b0;
          bits++;
          if (cut > 0 && bits == cut) stop = 1;
        end
      end
      miso_got[b] = int'(rcv);
    end
    repeat (hp + 2) @(negedge clk);
    cs_n_i = 1'b1;
    mosi_i = 1'b0;
    repeat (SYNC + 8) @(negedge clk);
    // R8: output idle once chip select released
    chk(miso_o == 1'b0, "R8 miso idle", miso_o, 0);
    if (cut == 0) begin
      // R4 / R10: every byte received in order
      chk(rx_got_q.size() == n, {req, " R4 byte count"}, rx_got_q.size(), n);
      for (int b = 0; b < n && b < rx_got_q.size(); b++)
        chk(rx_got_q[b] == int'(sb[b]), {req, " R4 rx byte"}, rx_got_q[b], sb[b]);
      // R7: one capture at select plus one per completed byte
      chk(cap_q.size() == n + 1, {req, " R7 tx_ready pulses"}, cap_q.size(), n + 1);
      if (chk_miso)
        for (int b = 0; b < n && b < cap_q.size(); b++)
          chk(miso_got[b] == cap_q[b], {req, " R6 miso byte"}, miso_got[b], cap_q[b]);
    end else begin
      // R5: aborted partial byte yields nothing
      chk(rx_got_q.size() == 0, {req, " R5 no partial byte"}, rx_got_q.size(), 0);
      chk(cap_q.size() == 1, {req, " R7 single capture"}, cap_q.size(), 1);
    end
  endtask

  // ---------------- watchdog -----------------------------------------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus -----------------------------------------------
  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk({rx_valid_o, tx_ready_o, miso_o, rx_data_o} == 11'h0, "R1 reset outputs",
        {rx_valid_o, tx_ready_o, miso_o, rx_data_o}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk({rx_valid_o, tx_ready_o, miso_o, rx_data_o} == 11'h0, "R1 idle after reset",
        {rx_valid_o, tx_ready_o, miso_o, rx_data_o}, 0);

    sb[0] = 8'hA7; sb[1] = 8'h00; sb[2] = 8'hFF; sb[3] = 8'h5A;
    frame(1, 8, 0, 0, 1, "single byte");
    sb[0] = 8'h81; sb[1] = 8'h7E; sb[2] = 8'hC3;
    frame(3, 8, 0, 0, 1, "R10 three bytes");
    sb[0] = 8'hF0;
    frame(1, 8, 0, 5, 0, "R5 abort");
    sb[0] = 8'h96;
    frame(1, 8, 0, 0, 1, "R5 after abort");
    sb[0] = 8'h4D; sb[1] = 8'hB2;
    frame(2, 8, 20, 0, 1, "R3 stretched high");
    sb[0] = 8'h1E; sb[1] = 8'hE1; sb[2] = 8'h55; sb[3] = 8'hAA;
    frame(4, 2, 0, 0, 0, "R9 4x ratio");

    repeat (20) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule